// File: doc/BRIEF.md
# Four-Phase Interleaved PWM Generator

This block drives four PWM lines that share one period and one pulse width. Each line is delayed by a quarter period from the line before it, which suits the four gate drives of an interleaved multi-phase converter. The period and the pulse width are given in clock cycles. The enable input starts and stops the whole set.

Internally there are two free-running period counters, a leader and a follower, kept a quarter period apart. Each counter drives two compare channels. The first channel on a counter raises a pulse centred in the count. The second channel defines a window of the complementary width, centred in the count, and inverts it. The resulting pulse is therefore centred on the counter wrap, half a period away from the first channel. New settings are taken only when the follower counter wraps, so all four lines change to the new duty on the same clock edge.

Top module: `quad_phase_pwm`

## Requirements
- R1: While enabled, each counter counts 0 up to P-1 and wraps to 0, where P is the latched period (P of 4 or more). Each output therefore repeats every P cycles.
- R2: On the first enabled edge the leader counter holds P/4 and the follower holds 0. After that the leader is always (follower + P/4) mod P.
- R3: pwm_o[0] (leader) and pwm_o[1] (follower) are high exactly when their counter value c satisfies S <= c < S+W, with S = (P-W)/2 (integer division). W is the latched width. Each output is registered and shows the counter value of the previous edge.
- R4: pwm_o[2] (leader) and pwm_o[3] (follower) are low exactly when G <= c < G+(P-W), with G = W/2. They are high at all other counts.
- R5: With P a multiple of 4 and W even, the rising edges fall in the order pwm_o[0], pwm_o[1], pwm_o[2], pwm_o[3], spaced P/4 apart.
- R6: A requested pulse width larger than the period is clamped to the period.
- R7: At W=0 all four outputs stay low. At W=P all four stay high. No single-cycle glitch occurs.
- R8: While enabled, new period and width inputs take effect only on the edge where the follower counter wraps. On that edge the leader is reloaded to the new P/4.
- R9: With enable low, all outputs are low on the next edge. The settings are taken straight from the inputs, and the counters are reloaded to their start values.
- R10: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the counters and outputs when high |
| period_in | input | CNT_W | Period P in clock cycles (4 or more) |
| pulse_in | input | CNT_W | Pulse width W in clock cycles |
| pwm_o | output | 4 | Phase outputs at 0, 90, 180 and 270 degrees |

## Verification
The assertions check on every cycle the invariants that do not depend on a scenario. These are: the quarter-period relation between the two counters, both counters staying below the period, the width never exceeding the period, the settings holding steady between follower wraps, all outputs forced low after a disabled edge, and the fixed outputs at 0% and 100% width. Only the bench scenarios can show the exact edge positions, the pulse widths, the rising-edge phase order, the clamp, and the moment a mid-run change of period and width takes effect. The bench compares every cycle against its own model.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
  // Limit the requested width to the period.
  function automatic logic [15:0] clamp_width(input logic [15:0] w, input logic [15:0] p);
    return (w > p) ? p : w;
  endfunction

  // Start count of a window of length len centred in a period p.
  function automatic logic [15:0] centre_start(input logic [15:0] p, input logic [15:0] len);
    return (p - len) >> 1;
  endfunction

  // True when c lies in [s, s+len).
  function automatic logic in_window(input logic [15:0] c, input logic [15:0] s,
                                     input logic [15:0] len);
    logic [16:0] stop;
    stop = {1'b0, s} + {1'b0, len};
    return ({1'b0, c} >= {1'b0, s}) && ({1'b0, c} < stop);
  endfunction
endpackage

// File: rtl/qpp_shadow.sv
module qpp_shadow #(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] pulse_in,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] pw_q
);
  import qpp_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= CNT_W'(DEF_PERIOD);
      pw_q  <= '0;
    end else if (take) begin
      per_q <= period_in;
      pw_q  <= clamp_width(pulse_in, period_in);
    end
  end
endmodule

// File: rtl/qpp_counter.sv
module qpp_counter #(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 600,
  parameter bit LEADER     = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] next_per,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] RST_VAL = LEADER ? CNT_W'(DEF_PERIOD / 4) : '0;

  logic [CNT_W-1:0] start_val;
  logic             at_top;

  generate
    if (LEADER) begin : g_lead
      assign start_val = next_per >> 2;
    end else begin : g_follow
      assign start_val = '0;
    end
  endgenerate

  assign at_top = (cnt == per - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= RST_VAL;
    else if (!run)    cnt <= start_val;
    else if (load)    cnt <= start_val;
    else if (at_top)  cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/qpp_channel.sv
module qpp_channel #(
  parameter int CNT_W  = 16,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] pw,
  output logic             pwm
);
  import qpp_pkg::*;

  logic [CNT_W-1:0] win_len;
  logic [CNT_W-1:0] win_start;
  logic             level;

  generate
    if (INVERT) begin : g_gap
      assign win_len   = per - pw;
      assign win_start = pw >> 1;
      assign level     = ~in_window(cnt, win_start, win_len);
    end else begin : g_pulse
      assign win_len   = pw;
      assign win_start = centre_start(per, pw);
      assign level     = in_window(cnt, win_start, win_len);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm <= 1'b0;
    else        pwm <= run & level;
  end
endmodule

// File: rtl/quad_phase_pwm.sv
module quad_phase_pwm #(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] pulse_in,
  output logic [3:0]       pwm_o
);
  localparam int N_CNT = 2;

  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] pw_q;
  logic [CNT_W-1:0] cnt [N_CNT];
  logic [CNT_W-1:0] cnt_a;
  logic [CNT_W-1:0] cnt_b;
  logic             b_wrap;
  logic             take;

  assign cnt_a  = cnt[0];
  assign cnt_b  = cnt[1];
  assign b_wrap = enable && (cnt_b == per_q - 1'b1);
  assign take   = !enable || b_wrap;

  qpp_shadow #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) u_shadow (
    .clk(clk), .rst_n(rst_n), .take(take),
    .period_in(period_in), .pulse_in(pulse_in),
    .per_q(per_q), .pw_q(pw_q)
  );

  generate
    for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
      qpp_counter #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD), .LEADER(k == 0)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(enable), .load(b_wrap),
        .per(per_q), .next_per(period_in), .cnt(cnt[k])
      );
    end
    for (genvar j = 0; j < 4; j++) begin : g_ch
      qpp_channel #(.CNT_W(CNT_W), .INVERT(j >= 2)) u_ch (
        .clk(clk), .rst_n(rst_n), .run(enable),
        .cnt(cnt[j % 2]), .per(per_q), .pw(pw_q), .pwm(pwm_o[j])
      );
    end
  endgenerate
endmodule

// File: rtl/quad_phase_pwm_chk.sv
module quad_phase_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [3:0]       pwm_o,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] cnt_b,
  input logic [CNT_W-1:0] per_q,
  input logic [CNT_W-1:0] pw_q,
  input logic             b_wrap
);
  logic [CNT_W:0] lead_sum;
  logic [CNT_W:0] lead_exp;
  assign lead_sum = {1'b0, cnt_b} + {1'b0, per_q >> 2};
  assign lead_exp = (lead_sum >= {1'b0, per_q}) ? lead_sum - {1'b0, per_q} : lead_sum;

  assert_quarter_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_a} == lead_exp);

  assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a < per_q) && (cnt_b < per_q));

  assert_width_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pw_q <= per_q);

  assert_settings_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !b_wrap) |=> ($stable(per_q) && $stable(pw_q)));

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (pwm_o == 4'h0));

  assert_full_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pw_q == per_q) |=> (pwm_o == 4'hF));

  assert_zero_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pw_q == '0) |=> (pwm_o == 4'h0));
endmodule

bind quad_phase_pwm quad_phase_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_o(pwm_o),
  .cnt_a(cnt_a), .cnt_b(cnt_b), .per_q(per_q), .pw_q(pw_q), .b_wrap(b_wrap)
);

// File: tb/test_quad_phase_pwm.sv
module test_quad_phase_pwm;
  localparam int W = 16;
  localparam int NV = 8;
  // each entry: {period, requested width}
  localparam logic [31:0] VEC [NV] = '{
    {16'd600, 16'd120}, {16'd600, 16'd0}, {16'd600, 16'd600}, {16'd40, 16'd10},
    {16'd40, 16'd13},   {16'd37, 16'd20}, {16'd8, 16'd2},     {16'd16, 16'd40}
  };

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [W-1:0] period_in = 16'd600, pulse_in = 16'd0;
  logic [3:0] pwm_o;

  always #10 clk = ~clk;

  quad_phase_pwm i_quad_phase_pwm (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .period_in(period_in), .pulse_in(pulse_in), .pwm_o(pwm_o)
  );

  int errors = 0, checks = 0;
  int m_per = 600, m_pw = 0, m_ca = 150, m_cb = 0, cyc = 0;
  int mism[4], highs[4], rise_t[4], prev_rise1, last_int1;
  logic [3:0] prev_o = 4'h0;

  function automatic logic win(int c, int s, int l);
    return (c >= s) && (c < s + l);
  endfunction

  function automatic logic [3:0] levels(int ca, int cb, int p, int w);
    int s, g, sp;
    s = (p - w) / 2; g = w / 2; sp = p - w;
    return {~win(cb, g, sp), ~win(ca, g, sp), win(cb, s, w), win(ca, s, w)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_tally();
    for (int i = 0; i < 4; i++) begin mism[i] = 0; highs[i] = 0; rise_t[i] = -1; end
    prev_rise1 = -1; last_int1 = -1;
  endtask

  task automatic step();
    logic [3:0] e;
    @(posedge clk);
    e = enable ? levels(m_ca, m_cb, m_per, m_pw) : 4'h0;
    if (!enable || m_cb == m_per - 1) begin
      m_per = int'(period_in);
      m_pw  = (int'(pulse_in) > m_per) ? m_per : int'(pulse_in);
      m_ca  = m_per / 4;
      m_cb  = 0;
    end else begin
      m_cb++;
      m_ca = (m_ca == m_per - 1) ? 0 : m_ca + 1;
    end
    #1;
    cyc++;
    for (int i = 0; i < 4; i++) begin
      if (pwm_o[i] !== e[i]) mism[i]++;
      if (pwm_o[i]) highs[i]++;
      if (pwm_o[i] && !prev_o[i]) begin
        if (i == 0) begin
          if (rise_t[0] >= 0) last_int1 = cyc - rise_t[0];
        end
        rise_t[i] = cyc;
      end
    end
    prev_o = pwm_o;
  endtask

  task automatic steps(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10: outputs low in reset
    repeat (3) @(posedge clk);
    #1 check(pwm_o == 4'h0, "R10 reset", pwm_o, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      int p, w, wc;
      string tag;
      p = int'(VEC[v][31:16]); w = int'(VEC[v][15:0]);
      wc = (w > p) ? p : w;
      @(negedge clk);
      enable = 1'b0; period_in = W'(p); pulse_in = W'(w);
      steps(3);
      check(pwm_o == 4'h0, "R9 idle low", pwm_o, 0);
      clear_tally();
      prev_o = 4'h0;
      @(negedge clk) enable = 1'b1;
      steps(p);
      for (int i = 0; i < 4; i++) highs[i] = 0;
      steps(p);
      for (int i = 0; i < 4; i++) begin
        tag = (w > p) ? "R6 clamp" : (wc == 0 || wc == p) ? "R7 extreme" :
              (i < 2) ? "R3 centred" : "R4 gap";
        check(mism[i] == 0, $sformatf("%s model out%0d", tag, i), mism[i], 0);
        check(highs[i] == wc, $sformatf("%s width out%0d", tag, i), highs[i], wc);
      end
      if (p % 4 == 0 && wc % 2 == 0 && wc > 0 && wc < p) begin
        for (int i = 1; i < 4; i++) begin
          int d;
          d = (((rise_t[i] - rise_t[0]) % p) + p) % p;
          check(d == i * p / 4, $sformatf("R5 R2 phase out%0d", i), d, i * p / 4);
        end
        check(last_int1 == p, "R1 period", last_int1, p);
      end
    end

    // R9: drop enable mid-run, outputs low next edge, restart aligned
    @(negedge clk); enable = 1'b0; period_in = 16'd40; pulse_in = 16'd10;
    steps(2);
    @(negedge clk) enable = 1'b1;
    clear_tally(); prev_o = 4'h0;
    steps(17);
    @(negedge clk) enable = 1'b0;
    step();
    check(pwm_o == 4'h0, "R9 disable low", pwm_o, 0);
    @(negedge clk) enable = 1'b1;
    steps(40);
    check(mism[0] + mism[1] + mism[2] + mism[3] == 0, "R9 restart", mism[0], 0);

    // R8: change settings mid-period, takes effect at follower wrap only
    clear_tally();
    steps(7);
    @(negedge clk) begin period_in = 16'd48; pulse_in = 16'd30; end
    steps(33);
    check(highs[0] == 10, "R8 old width kept", highs[0], 10);
    steps(48);
    for (int i = 0; i < 4; i++) highs[i] = 0;
    steps(48);
    check(highs[0] == 30 && highs[3] == 30, "R8 new width", highs[0], 30);
    check(mism[0] + mism[1] + mism[2] + mism[3] == 0, "R8 update model", mism[1], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule